// File: doc/BRIEF.md
# Slow-Clock Update Bridge

This block hands multi-bit values from a fast system clock to logic that runs on an unrelated, much slower clock. The slow clock is not used as a clock here. It is sampled as data by the fast clock through a chain of synchronizing flops. A rising transition seen at the end of that chain produces a strobe that lasts one fast cycle. Every register in the block lives in the fast domain.

A writer presents a word with a one-cycle valid. The word waits in a staging register, and a pending flag marks it as not yet delivered. When the strobe fires, the word is copied into a holding register that the slow domain reads, and the flag is cleared. The holding register changes only just after a slow rising edge. It then stays still for nearly a whole slow period, so the slow side always samples a coherent word. No data bit is ever synchronized on its own.

Top module: `slow_update_bridge`

## Requirements
- R1: While reset is asserted and right after it is released, `slow_data`, `pending` and `slow_en` are all 0.
- R2: `slow_en` is high for exactly one fast cycle for each low-to-high transition of `slow_clk`. It is never high in two consecutive cycles, and a falling transition produces no strobe.
- R3: If `slow_clk` is first sampled high at fast edge 1, `slow_en` is high in the cycle that follows fast edge N, where N = SYNC_STAGES + EXTRA_STAGES (2 by default).
- R4: If `slow_clk` is already high when reset is released, no strobe is produced until `slow_clk` has been seen low and then high again.
- R5: A cycle with `upd_valid` high and `slow_en` low sets `pending` on the next edge. `pending` then stays 1 until a cycle in which `slow_en` is high.
- R6: In a cycle with `slow_en` high and `pending` high, the staged word is copied to `slow_data` and `pending` is cleared on the next edge.
- R7: If `upd_valid` and `slow_en` are high in the same cycle, `slow_data` takes that cycle's `upd_data` and `pending` becomes 0.
- R8: A strobe with nothing pending and no update leaves `slow_data` unchanged.
- R9: `slow_data` changes only on the edge that ends a cycle with `slow_en` high. An update that arrives one cycle after the strobe is held, with `pending` at 1, until the next strobe delivers it.
- R10: If several updates arrive between two strobes, the last one is delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low reset. It asserts asynchronously and must be released synchronously to `clk` |
| slow_clk | input | 1 | Unrelated slow clock, sampled as data |
| upd_valid | input | 1 | One-cycle write strobe for a new word |
| upd_data | input | W | Word to be handed over |
| slow_data | output | W | Holding register read by the slow domain |
| pending | output | 1 | 1 while a written word has not yet been delivered |
| slow_en | output | 1 | One-cycle strobe after each slow rising edge |

## Verification
The hardest situations to reach are an update that lands exactly on the strobe cycle and an update that lands one cycle on either side of it. The strobe's timing depends on the length of the synchronizer chain. The stimulus raises `slow_clk` on a known falling edge of `clk` and counts fast edges from that point. It then places `upd_valid` at a chosen count relative to the expected strobe: one before, on it, and one after. Starting from reset with `slow_clk` already high covers the case of a false edge at start-up.

// File: rtl/slow_update_pkg.sv
package slow_update_pkg;
  localparam int unsigned DEF_WIDTH   = 8;
  localparam int unsigned DEF_SYNC    = 2;
  localparam int unsigned MIN_SYNC    = 2;
  localparam int unsigned DEF_EXTRA   = 0;
endpackage

// File: rtl/slow_edge_sense.sv
module slow_edge_sense #(
  parameter int unsigned SYNC_STAGES  = slow_update_pkg::DEF_SYNC,
  parameter int unsigned EXTRA_STAGES = slow_update_pkg::DEF_EXTRA
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_clk,
  output logic edge_en
);
  localparam int unsigned CHAIN = SYNC_STAGES + EXTRA_STAGES;

  logic [CHAIN-1:0] chain_q;
  logic             dly_q;
  logic [CHAIN:0]   real_q;
  logic [CHAIN:0]   real_d;

  // synchronizer and settling stages
  generate
    for (genvar i = 0; i < CHAIN; i++) begin : g_stage
      logic stage_in;
      if (i == 0) begin : g_first
        assign stage_in = slow_clk;
      end else begin : g_next
        assign stage_in = chain_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= stage_in;
      end
    end
  endgenerate

  // marks which stages hold a genuine sample since reset
  always_comb begin
    real_d = {real_q[CHAIN-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q  <= 1'b0;
      real_q <= '0;
    end else begin
      dly_q  <= chain_q[CHAIN-1];
      real_q <= real_d;
    end
  end

  assign edge_en = chain_q[CHAIN-1] & ~dly_q & real_q[CHAIN];
endmodule

// File: rtl/slow_update_hold.sv
module slow_update_hold #(
  parameter int unsigned W = slow_update_pkg::DEF_WIDTH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         edge_en,
  input  logic         upd_valid,
  input  logic [W-1:0] upd_data,
  output logic [W-1:0] hold_data,
  output logic         pending
);
  logic [W-1:0] stage_q;
  logic [W-1:0] hold_q;
  logic [W-1:0] hold_d;
  logic         pend_q;
  logic         pend_d;
  logic         hold_ce;

  always_comb begin
    pend_d  = pend_q;
    hold_d  = hold_q;
    hold_ce = 1'b0;
    if (edge_en) begin
      pend_d = 1'b0;
      if (upd_valid) begin
        hold_d  = upd_data;
        hold_ce = 1'b1;
      end else if (pend_q) begin
        hold_d  = stage_q;
        hold_ce = 1'b1;
      end
    end else if (upd_valid) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      hold_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (upd_valid) stage_q <= upd_data;
      if (hold_ce)   hold_q  <= hold_d;
    end
  end

  assign hold_data = hold_q;
  assign pending   = pend_q;
endmodule

// File: rtl/slow_update_bridge.sv
module slow_update_bridge #(
  parameter int unsigned W            = slow_update_pkg::DEF_WIDTH,
  parameter int unsigned SYNC_STAGES  = slow_update_pkg::DEF_SYNC,
  parameter int unsigned EXTRA_STAGES = slow_update_pkg::DEF_EXTRA
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         slow_clk,
  input  logic         upd_valid,
  input  logic [W-1:0] upd_data,
  output logic [W-1:0] slow_data,
  output logic         pending,
  output logic         slow_en
);
  localparam int unsigned SYNC_USED =
    (SYNC_STAGES < slow_update_pkg::MIN_SYNC) ? slow_update_pkg::MIN_SYNC : SYNC_STAGES;

  logic edge_en;

  slow_edge_sense #(
    .SYNC_STAGES (SYNC_USED),
    .EXTRA_STAGES(EXTRA_STAGES)
  ) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .slow_clk(slow_clk),
    .edge_en (edge_en)
  );

  slow_update_hold #(
    .W(W)
  ) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .edge_en  (edge_en),
    .upd_valid(upd_valid),
    .upd_data (upd_data),
    .hold_data(slow_data),
    .pending  (pending)
  );

  assign slow_en = edge_en;
endmodule

// File: rtl/slow_update_bridge_chk.sv
module slow_update_bridge_chk #(
  parameter int unsigned W = slow_update_pkg::DEF_WIDTH
) (
  input logic         clk,
  input logic         rst_n,
  input logic         upd_valid,
  input logic [W-1:0] upd_data,
  input logic [W-1:0] slow_data,
  input logic         pending,
  input logic         slow_en
);
  AST_EN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    slow_en |=> !slow_en); // R2

  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !slow_en) |=> pending); // R5

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !slow_en) |=> pending); // R5

  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    slow_en |=> !pending); // R6

  AST_SAME_CYCLE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_en && upd_valid) |=> (slow_data == $past(upd_data))); // R7

  AST_IDLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_en && !pending && !upd_valid) |=> $stable(slow_data)); // R8

  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_en |=> $stable(slow_data)); // R9
endmodule

bind slow_update_bridge slow_update_bridge_chk #(.W(W)) u_chk (.*);

// File: tb/slow_update_bridge_tb.sv
module slow_update_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int SYNC       = 2;
  localparam int EXTRA      = 0;
  localparam int N          = SYNC + EXTRA;
  localparam int NVEC       = 6;
  localparam logic [W-1:0] VEC [NVEC] = '{8'h7F, 8'h80, 8'hFF, 8'h00, 8'hA5, 8'h3C};

  logic         clk;
  logic         rst_n;
  logic         slow_clk;
  logic         upd_valid;
  logic [W-1:0] upd_data;
  logic [W-1:0] slow_data;
  logic         pending;
  logic         slow_en;

  int checks;
  int errors;
  int dbl;
  logic prev_en;
  logic [W-1:0] expect_data;

  slow_update_bridge #(.W(W), .SYNC_STAGES(SYNC), .EXTRA_STAGES(EXTRA)) u_dut (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .upd_valid(upd_valid),
    .upd_data(upd_data), .slow_data(slow_data), .pending(pending), .slow_en(slow_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R2 monitor: strobe never high in consecutive cycles
  always @(negedge clk) begin
    if (rst_n && prev_en && slow_en) dbl++;
    prev_en <= rst_n ? slow_en : 1'b0;
  end

  task automatic write(input logic [W-1:0] d);
    upd_valid = 1'b1;
    upd_data  = d;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  // raise slow clock at a falling fast edge; optionally place an update at count 'at'
  task automatic rise(input bit do_upd, input int at, input logic [W-1:0] d,
                      output int lat, output int pulses);
    lat = 0;
    pulses = 0;
    slow_clk = 1'b1;
    for (int k = 1; k <= N + 4; k++) begin
      @(negedge clk);
      if (slow_en) begin
        pulses++;
        if (lat == 0) lat = k;
      end
      upd_valid = do_upd && (k == at);
      upd_data  = d;
    end
    upd_valid = 1'b0;
  endtask

  task automatic fall(output int pulses);
    pulses = 0;
    slow_clk = 1'b0;
    for (int k = 0; k < N + 4; k++) begin
      @(negedge clk);
      if (slow_en) pulses++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lat;
    int p;
    checks = 0; errors = 0; dbl = 0; prev_en = 1'b0;
    rst_n = 1'b0; slow_clk = 1'b0; upd_valid = 1'b0; upd_data = '0;
    expect_data = '0;
    repeat (3) @(negedge clk);
    check("R1 reset slow_data", slow_data, 0);
    check("R1 reset pending", pending, 0);
    check("R1 reset slow_en", slow_en, 0);
    rst_n = 1'b1;
    repeat (N + 3) @(negedge clk);
    check("R1 post-reset pending", pending, 0);

    // table walk: write a word, raise slow clock, confirm delivery
    for (int v = 0; v < NVEC; v++) begin
      write(VEC[v]);
      check("R5 pending after write", pending, 1);
      check("R9 data held before strobe", slow_data, expect_data);
      rise(1'b0, 0, '0, lat, p);
      check("R3 strobe latency", lat, N);
      check("R2 one strobe per rise", p, 1);
      expect_data = VEC[v];
      check("R6 delivered word", slow_data, expect_data);
      check("R6 pending cleared", pending, 0);
      fall(p);
      check("R2 no strobe on fall", p, 0);
    end

    // R10: last of several updates wins
    write(8'h11);
    write(8'h22);
    write(8'h33);
    rise(1'b0, 0, '0, lat, p);
    check("R10 last update delivered", slow_data, 8'h33);
    fall(p);

    // R8: strobe with nothing pending
    rise(1'b0, 0, '0, lat, p);
    check("R8 strobe occurred", p, 1);
    check("R8 data unchanged", slow_data, 8'h33);
    fall(p);

    // R7: update in the strobe cycle
    rise(1'b1, N, 8'h5A, lat, p);
    check("R7 same-cycle capture", slow_data, 8'h5A);
    check("R7 pending cleared", pending, 0);
    fall(p);

    // update one cycle before strobe
    rise(1'b1, N - 1, 8'h66, lat, p);
    check("R6 update before strobe delivered", slow_data, 8'h66);
    check("R6 pending cleared", pending, 0);
    fall(p);

    // R9: update one cycle after strobe is kept for next edge
    rise(1'b1, N + 1, 8'hC3, lat, p);
    check("R9 late update not yet delivered", slow_data, 8'h66);
    check("R9 late update still pending", pending, 1);
    fall(p);
    check("R9 pending across fall", pending, 1);
    rise(1'b0, 0, '0, lat, p);
    check("R9 late update delivered next edge", slow_data, 8'hC3);
    fall(p);

    // R4: slow clock high through reset release
    @(negedge clk);
    slow_clk = 1'b1;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    p = 0;
    for (int k = 0; k < N + 8; k++) begin
      @(negedge clk);
      if (slow_en) p++;
    end
    check("R4 no false strobe after reset", p, 0);
    check("R1 data cleared by reset", slow_data, 0);
    fall(p);
    rise(1'b0, 0, '0, lat, p);
    check("R4 real edge strobes", p, 1);
    fall(p);

    check("R2 no back-to-back strobe", dbl, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule